// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarms

This block keeps wall-clock time from a 32.768 kHz clock. A divider turns that clock into a one-cycle pulse once per second. The pulse advances a chain of wrapping counters for seconds, minutes, hours and a 15-bit day number. Two alarm comparators watch the counters. The first matches a time of day on any day. The second matches one particular day together with a time of day. A countdown stopwatch shares the same one-second pulse.

Every event sets a sticky status bit, and software clears a status bit by writing a 1 to it. An enable mask selects which status bits drive the single wakeup output. Software loads the time, both alarm targets and the stopwatch, and sets the mask, through a simple write port. A registered read port returns any of these registers. The whole block runs in the 32.768 kHz clock domain.

Top module: `rtc_calendar_top`

## Requirements
- R1: After a write to the time register, the time first advances exactly PRESCALE clock cycles after that write. It then advances once every PRESCALE cycles. The write restarts the divider from zero.
- R2: Seconds and minutes count 0 to 59 and hours 0 to 23, each carrying into the next unit. The day counter covers 0 to 2^DAY_W-1 (32767 by default) and wraps to 0.
- R3: The status register (address 5) has the following bits. Bit 0 is set on every one-second advance. Bit 1 is set when seconds wrap 59 to 0. Bit 2 is set when minutes wrap 59 to 0. Bit 3 is set when hours wrap 23 to 0.
- R4: Status bit 4 is set when hours, minutes and seconds after an advance equal the time-of-day alarm (address 1), whatever the day.
- R5: Status bit 5 is set only when day, hours, minutes and seconds after an advance all equal the dated alarm (address 2).
- R6: An alarm sets its status bit once, in the cycle that follows the advance into the matching second. If software clears the bit later in that same second, the bit stays clear.
- R7: Writing address 3 loads the stopwatch and starts it. While enable bit 6 is set, it decrements on each one-second advance. An advance that finds it at zero sets status bit 6. While enable bit 6 is clear, the stopwatch holds its value.
- R8: After an underflow the stopwatch stops at zero, with running flag bit 31 of address 3 clear. It raises no further event until software reloads it.
- R9: Writing address 5 clears exactly the status bits written as 1. Bits written as 0 are kept.
- R10: wake_o is high one cycle after any status bit whose enable bit (address 4, same bit position) is set. Status bits whose enable is clear do not drive it.
- R11: After reset, time, alarms, stopwatch, enables, status and wake_o are all zero.
- R12: Time and alarm words are laid out with seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and day in bits 31:17. Registers read back as written at addresses 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 time, 1 day-free alarm, 2 dated alarm, 3 stopwatch, 4 enable, 5 status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 32 | Registered read data, valid one cycle after rd_addr |
| cal_now | output | 32 | Live calendar word in the time layout |
| wake_o | output | 1 | Combined wakeup event |

## Verification
The counter chain is swept second by second through more than an hour that crosses two hour boundaries and a day boundary. Each step is compared with a time computed arithmetically, which separates the carry logic of each unit. A second load at the last day and last second checks that all four rollover flags set together and that the day number wraps. Alarms are tested against three cases: the right time on a wrong day, the right time on the right day, and a clear during the matching second. These cases separate the two comparator kinds and the single firing. The stopwatch is run enabled past its underflow and also held disabled, which separates counting, stopping and enable gating.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int N_EVT = 7;

  localparam int EV_SEC   = 0;
  localparam int EV_MIN   = 1;
  localparam int EV_HOUR  = 2;
  localparam int EV_DAY   = 3;
  localparam int EV_ATOD  = 4;
  localparam int EV_ADAY  = 5;
  localparam int EV_SWUF  = 6;

  typedef enum logic [2:0] {
    RA_TIME   = 3'd0,
    RA_ATOD   = 3'd1,
    RA_ADAY   = 3'd2,
    RA_SWATCH = 3'd3,
    RA_ENABLE = 3'd4,
    RA_STATUS = 3'd5
  } rtc_addr_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R1: a pulse is never followed directly by another one
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R1: a restart delays the next pulse
  a_r1_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick);
endmodule

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt #(
  parameter int W   = 6,
  parameter int MAX = 59
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] val,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = W'(MAX);

  assign wrap = inc && !load && (val == TOP);

  always_ff @(posedge clk) begin
    if (rst)       val <= '0;
    else if (load) val <= load_val;
    else if (inc)  val <= (val == TOP) ? '0 : val + 1'b1;
  end

  // R2: the top value steps back to zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && val == TOP) |=> (val == '0));
  // R2: without a step or a load the unit holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(val));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper #(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [DAY_W+16:0] load_word,
  output logic [DAY_W+16:0] now_word,
  output logic             roll_min,
  output logic             roll_hour,
  output logic             roll_day
);
  localparam int TW = DAY_W + 17;

  logic [5:0]       sec_v, min_v;
  logic [4:0]       hour_v;
  logic [DAY_W-1:0] day_v;
  logic             day_wrap;

  rtc_wrap_cnt #(.W(6), .MAX(59)) u_sec (
    .clk(clk), .rst(rst), .inc(step), .load(load),
    .load_val(load_word[5:0]), .val(sec_v), .wrap(roll_min));

  rtc_wrap_cnt #(.W(6), .MAX(59)) u_min (
    .clk(clk), .rst(rst), .inc(roll_min), .load(load),
    .load_val(load_word[11:6]), .val(min_v), .wrap(roll_hour));

  rtc_wrap_cnt #(.W(5), .MAX(23)) u_hour (
    .clk(clk), .rst(rst), .inc(roll_hour), .load(load),
    .load_val(load_word[16:12]), .val(hour_v), .wrap(roll_day));

  rtc_wrap_cnt #(.W(DAY_W), .MAX((1 << DAY_W) - 1)) u_day (
    .clk(clk), .rst(rst), .inc(roll_day), .load(load),
    .load_val(load_word[TW-1:17]), .val(day_v), .wrap(day_wrap));

  assign now_word = {day_v, hour_v, min_v, sec_v};

  // R2: a day carry only comes from a full hour chain
  a_r2_day_carry: assert property (@(posedge clk) disable iff (rst)
    roll_day |-> (sec_v == 6'd59 && min_v == 6'd59));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int DAY_W   = 15,
  parameter bit USE_DAY = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DAY_W+16:0] now_word,
  input  logic [DAY_W+16:0] tgt_word,
  output logic              hit
);
  localparam int TW = DAY_W + 17;

  logic tod_eq, day_eq;

  assign tod_eq = (now_word[16:0] == tgt_word[16:0]);

  generate
    if (USE_DAY) begin : g_dated
      assign day_eq = (now_word[TW-1:17] == tgt_word[TW-1:17]);
    end else begin : g_anyday
      assign day_eq = 1'b1;
    end
  endgenerate

  assign hit = upd && tod_eq && day_eq;

  // R6: one firing per matching second
  a_r6_single_hit: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
  parameter int SW_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            run_en,
  input  logic            load,
  input  logic [SW_W-1:0] load_val,
  output logic [SW_W-1:0] value,
  output logic            running,
  output logic            under
);
  assign under = step && run_en && running && !load && (value == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      value   <= '0;
      running <= 1'b0;
    end else if (load) begin
      value   <= load_val;
      running <= 1'b1;
    end else if (step && run_en && running) begin
      if (value == '0) running <= 1'b0;
      else             value   <= value - 1'b1;
    end
  end

  // R8: an underflow stops the countdown
  a_r8_stop_after_under: assert property (@(posedge clk) disable iff (rst)
    under |=> !running);
  // R8: a stopped countdown stays frozen until reloaded
  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    (!running && !load) |=> (!running && $stable(value)));
  // R7: disabled countdown keeps its value
  a_r7_gated: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !load) |=> $stable(value));
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top #(
  parameter int PRESCALE = 32768,
  parameter int DAY_W    = 15,
  parameter int SW_W     = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic [31:0] cal_now,
  output logic        wake_o
);
  import rtc_pkg::*;

  localparam int TW     = DAY_W + 17;
  localparam int N_ALRM = 2;

  logic wr_time, wr_sw, wr_en_reg, wr_status;
  logic tick, step, upd_q;
  logic roll_min, roll_hour, roll_day;
  logic [TW-1:0] now_word;
  logic [TW-1:0] alarm_q [N_ALRM];
  logic [N_ALRM-1:0] alarm_hit;
  logic [SW_W-1:0] sw_val;
  logic sw_run, sw_under;
  logic [N_EVT-1:0] en_q, st_q, evt, clr;

  assign wr_time   = wr_en && (wr_addr == RA_TIME);
  assign wr_sw     = wr_en && (wr_addr == RA_SWATCH);
  assign wr_en_reg = wr_en && (wr_addr == RA_ENABLE);
  assign wr_status = wr_en && (wr_addr == RA_STATUS);

  rtc_prescaler #(.DIV(PRESCALE)) u_div (
    .clk(clk), .rst(rst), .restart(wr_time), .tick(tick));

  assign step = tick && !wr_time;

  rtc_timekeeper #(.DAY_W(DAY_W)) u_time (
    .clk(clk), .rst(rst), .step(step), .load(wr_time),
    .load_word(wr_data[TW-1:0]), .now_word(now_word),
    .roll_min(roll_min), .roll_hour(roll_hour), .roll_day(roll_day));

  always_ff @(posedge clk) begin
    if (rst) upd_q <= 1'b0;
    else     upd_q <= step;
  end

  generate
    for (genvar g = 0; g < N_ALRM; g++) begin : g_alarm
      always_ff @(posedge clk) begin
        if (rst) alarm_q[g] <= '0;
        else if (wr_en && wr_addr == 3'(g + 1)) alarm_q[g] <= wr_data[TW-1:0];
      end

      rtc_alarm #(.DAY_W(DAY_W), .USE_DAY(g == 1)) u_alarm (
        .clk(clk), .rst(rst), .upd(upd_q), .now_word(now_word),
        .tgt_word(alarm_q[g]), .hit(alarm_hit[g]));
    end
  endgenerate

  rtc_stopwatch #(.SW_W(SW_W)) u_sw (
    .clk(clk), .rst(rst), .step(step), .run_en(en_q[EV_SWUF]),
    .load(wr_sw), .load_val(wr_data[SW_W-1:0]),
    .value(sw_val), .running(sw_run), .under(sw_under));

  always_comb begin
    evt           = '0;
    evt[EV_SEC]   = step;
    evt[EV_MIN]   = roll_min;
    evt[EV_HOUR]  = roll_hour;
    evt[EV_DAY]   = roll_day;
    evt[EV_ATOD]  = alarm_hit[0];
    evt[EV_ADAY]  = alarm_hit[1];
    evt[EV_SWUF]  = sw_under;
    clr           = wr_status ? wr_data[N_EVT-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      st_q   <= '0;
      wake_o <= 1'b0;
    end else begin
      if (wr_en_reg) en_q <= wr_data[N_EVT-1:0];
      st_q   <= (st_q & ~clr) | evt;
      wake_o <= |(st_q & en_q);
    end
  end

  always_comb begin
    cal_now           = '0;
    cal_now[TW-1:0]   = now_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      case (rd_addr)
        RA_TIME:   rd_data[TW-1:0] <= now_word;
        RA_ATOD:   rd_data[TW-1:0] <= alarm_q[0];
        RA_ADAY:   rd_data[TW-1:0] <= alarm_q[1];
        RA_SWATCH: begin
          rd_data[SW_W-1:0] <= sw_val;
          rd_data[31]       <= sw_run;
        end
        RA_ENABLE: rd_data[N_EVT-1:0] <= en_q;
        RA_STATUS: rd_data[N_EVT-1:0] <= st_q;
        default:   rd_data <= '0;
      endcase
    end
  end

  // R3: every advance leaves the seconds flag set
  a_r3_sec_flag: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> st_q[EV_SEC]);
  // R9: a written 1 clears a bit that has no new event
  a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_status && wr_data[EV_ATOD] && !evt[EV_ATOD]) |=> !st_q[EV_ATOD]);
  // R9: a written 0 keeps a set bit
  a_r9_keep: assert property (@(posedge clk) disable iff (rst)
    (st_q[EV_ADAY] && !(wr_status && wr_data[EV_ADAY])) |=> st_q[EV_ADAY]);
  // R10: wakeup needs an enabled pending event one cycle earlier
  a_r10_wake_src: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> ($past(en_q) != '0 && $past(st_q) != '0));
endmodule

// File: tb/rtc_calendar_top_tb_top.sv
module rtc_calendar_top_tb_top;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] cal_now;
  logic        wake_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rtc_calendar_top #(.PRESCALE(P), .DAY_W(15), .SW_W(8)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cal_now(cal_now), .wake_o(wake_o));

  function automatic logic [31:0] tw(int d, int h, int m, int s);
    return (32'(d) << 17) | (32'(h) << 12) | (32'(m) << 6) | 32'(s);
  endfunction

  function automatic longint secs_of(int d, int h, int m, int s);
    return ((longint'(d) * 24 + h) * 60 + m) * 60 + s;
  endfunction

  function automatic logic [31:0] word_at(longint t);
    longint w, r;
    w = t % (longint'(32768) * 86400);
    r = w % 86400;
    return tw(int'(w / 86400), int'(r / 3600), int'((r % 3600) / 60), int'(r % 60));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic adv(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    longint t0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 time", cal_now, 0);
    check("R11 wake", 32'(wake_o), 0);
    rd(3'd5, v); check("R11 status", v, 0);
    rd(3'd3, v); check("R11 stopwatch", v, 0);
    rd(3'd4, v); check("R11 enable", v, 0);

    // R1 divider timing after a time write
    wr(3'd0, tw(3, 10, 20, 30));
    adv(P - 1); check("R1 before first advance", cal_now, tw(3, 10, 20, 30));
    adv(1);     check("R1 first advance", cal_now, tw(3, 10, 20, 31));
    adv(P - 1); check("R1 between advances", cal_now, tw(3, 10, 20, 31));
    adv(1);     check("R1 second advance", cal_now, tw(3, 10, 20, 32));
    wr(3'd0, tw(3, 10, 20, 40));
    adv(P - 1); check("R1 restart", cal_now, tw(3, 10, 20, 40));
    adv(1);     check("R1 restart advance", cal_now, tw(3, 10, 20, 41));

    // R2 sweep across hour and day boundaries
    t0 = secs_of(12, 22, 58, 10);
    wr(3'd0, word_at(t0));
    for (int k = 1; k <= 3720; k++) begin
      adv(P);
      check("R2 sweep", cal_now, word_at(t0 + k));
    end

    // R2 R3 last day wraps, all rollover flags
    wr(3'd5, 32'h7f);
    wr(3'd0, tw(32767, 23, 59, 58));
    adv(P);
    rd(3'd5, v); check("R3 seconds flag only", v & 32'hf, 32'h1);
    adv(P - 1);
    check("R2 day wrap", cal_now, tw(0, 0, 0, 0));
    rd(3'd5, v); check("R3 all rollovers", v & 32'hf, 32'hf);
    // R9 selective clear
    wr(3'd5, 32'h2);
    rd(3'd5, v); check("R9 clear one bit", v & 32'hf, 32'hd);

    // R4 R6 R10 day-free alarm
    wr(3'd5, 32'h7f);
    wr(3'd1, tw(0, 6, 30, 3));
    wr(3'd4, 32'h10);
    wr(3'd0, tw(100, 6, 30, 0));
    adv(2 * P);
    rd(3'd5, v); check("R4 not yet", (v >> 4) & 1, 0);
    adv(P);
    rd(3'd5, v); check("R4 alarm fires", (v >> 4) & 1, 1);
    check("R10 wake high", 32'(wake_o), 1);
    wr(3'd5, 32'h10);
    rd(3'd5, v); check("R6 no refire in second", (v >> 4) & 1, 0);
    check("R10 wake low", 32'(wake_o), 0);
    adv(P);
    rd(3'd5, v); check("R6 next second", (v >> 4) & 1, 0);

    // R5 dated alarm, wrong day then right day
    wr(3'd5, 32'h7f);
    wr(3'd2, tw(9, 12, 0, 5));
    wr(3'd1, tw(0, 12, 0, 5));
    wr(3'd4, 32'h30);
    wr(3'd0, tw(8, 12, 0, 0));
    adv(6 * P);
    rd(3'd5, v);
    check("R5 wrong day", (v >> 5) & 1, 0);
    check("R4 any day", (v >> 4) & 1, 1);
    wr(3'd5, 32'h7f);
    wr(3'd0, tw(9, 12, 0, 0));
    adv(6 * P);
    rd(3'd5, v); check("R5 right day", (v >> 5) & 1, 1);
    // R10 masked events do not wake
    wr(3'd4, 32'h0);
    adv(2);
    check("R10 masked", 32'(wake_o), 0);
    rd(3'd5, v); check("R9 kept while unwritten", (v >> 5) & 1, 1);
    // R12 readback
    rd(3'd2, v); check("R12 dated alarm", v, tw(9, 12, 0, 5));
    rd(3'd1, v); check("R12 day-free alarm", v, tw(0, 12, 0, 5));

    // R7 R8 stopwatch
    wr(3'd5, 32'h7f);
    wr(3'd0, tw(0, 0, 0, 0));
    wr(3'd3, 32'd3);
    wr(3'd4, 32'h40);
    adv(4 * P - 3);
    rd(3'd5, v); check("R7 before underflow", (v >> 6) & 1, 0);
    rd(3'd5, v); check("R7 underflow", (v >> 6) & 1, 1);
    rd(3'd3, v); check("R8 stopped at zero", v, 0);
    wr(3'd5, 32'h40);
    adv(3 * P);
    rd(3'd5, v); check("R8 no second event", (v >> 6) & 1, 0);
    rd(3'd4, v); check("R12 enable", v, 32'h40);
    wr(3'd4, 32'h0);
    wr(3'd3, 32'd2);
    adv(5 * P);
    rd(3'd3, v); check("R7 held when disabled", v, 32'h8000_0002);

    finish_run();
  end
endmodule